// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block is a memory-mapped slave that occupies a 4 KB little-endian register window. It turns message-signalled interrupt writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A device that wants to raise an interrupt writes an absolute interrupt number to a doorbell register. The frame subtracts the first interrupt number it owns, which is the configured base plus 32, and checks the result against the line count. If the number is in range, the frame pulses the matching output line. If it is not, the write is dropped without any effect.

Software finds the frame's range by reading a type register, which reports the first interrupt number and the number of lines. An identification register carries a product code. Every other readable offset returns zero, including the whole identification block at the top of the window.

Requests arrive on a simple 32-bit bus made of valid, ready, write, address, byte size and write data. Read data comes back one cycle after acceptance through a valid/ready response channel.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A 4-byte read at offset 0x008 returns BASE_ID+32 in bits [31:16] and LINE_COUNT in bits [15:0].
- R2: A 4-byte read at offset 0xFCC returns PRODUCT_CODE in bits [31:20] and zero in bits [19:0].
- R3: A 4-byte read at any other offset returns zero. This covers the span 0xFD0 to 0xFFC and the doorbell offset 0x040.
- R4: A read whose `req_size` byte count (1, 2 or 4 are the legal codes) is not 4 returns zero, at any offset.
- R5: Read data appears with `rsp_valid` in the cycle after the read is accepted. While `rsp_ready` is low, the response is held stable and `req_ready` stays low.
- R6: A write at offset 0x040 with `req_size` of 2 or 4 takes `req_wdata[9:0]` as an interrupt number N. If BASE_ID+32 <= N < BASE_ID+32+LINE_COUNT, line N-(BASE_ID+32) of `irq_pulse` is high for exactly the one cycle after acceptance. Bits [31:10] of the write data are ignored.
- R7: A doorbell write whose number lies outside that range leaves every `irq_pulse` line low.
- R8: A write with a size other than 2 or 4, a write to any offset other than 0x040, and any read all leave every `irq_pulse` line low.
- R9: Valid doorbell writes accepted in consecutive cycles to different lines pulse each line in its own cycle, and none is lost. This also holds when a write is accepted on the same edge that retires a stalled read response.
- R10: At most one `irq_pulse` line is high at a time. After reset, all lines are low, `rsp_valid` is low and `req_ready` is high.
- R11: A configuration with LINE_COUNT outside 1..128, or with BASE_ID+32+LINE_COUNT above 1020, fails at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Frame can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read response data |
| irq_pulse | output | LINE_COUNT | One-cycle interrupt pulses, one per line |

## Verification
Two events can fall on the same clock edge: the retirement of a read response that has been held back, and the acceptance of a new doorbell write. The bench provokes this by holding `rsp_ready` low after a read and keeping a doorbell write pending. It then releases `rsp_ready`, so that the response retires and the write is accepted on one edge. The expected result is that `rsp_valid` drops, the held data never changed, and the pulse appears on the correct line in the following cycle. A second overlap comes from back-to-back doorbells, where one line's pulse ends on the same edge that the next line's pulse begins. The bench checks each cycle's one-hot pattern against line indices it computes itself.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
    localparam logic [11:0] OFS_TYPE     = 12'h008;
    localparam logic [11:0] OFS_DOORBELL = 12'h040;
    localparam logic [11:0] OFS_IDENT    = 12'hFCC;
    localparam logic [2:0]  SZ_HALF      = 3'd2;
    localparam logic [2:0]  SZ_WORD      = 3'd4;
    localparam int          ID_BIAS      = 32;

    typedef struct packed {
        logic        rsp_valid;
        logic [31:0] rsp_data;
    } rsp_state_t;
endpackage

// File: rtl/msi_id_rebase.sv
module msi_id_rebase #(
    parameter int BASE_ID    = 0,
    parameter int LINE_COUNT = 64,
    parameter int IDX_W      = 6
) (
    input  logic [9:0]       irq_id,
    output logic             in_range,
    output logic [IDX_W-1:0] line_idx
);
    localparam int FIRST_ID = BASE_ID + msi_frame_pkg::ID_BIAS;

    logic [10:0] offset;

    always_comb begin
        offset   = {1'b0, irq_id} - 11'(FIRST_ID);
        in_range = ({1'b0, irq_id} >= 11'(FIRST_ID)) && (offset < 11'(LINE_COUNT));
        line_idx = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux #(
    parameter int          BASE_ID      = 0,
    parameter int          LINE_COUNT   = 64,
    parameter logic [11:0] PRODUCT_CODE = 12'h051
) (
    input  logic [11:0] rd_addr,
    input  logic [2:0]  rd_size,
    output logic [31:0] rd_data
);
    import msi_frame_pkg::*;

    localparam logic [15:0] FIRST_ID = 16'(BASE_ID + ID_BIAS);
    localparam logic [31:0] TYPE_VAL = {FIRST_ID, 16'(LINE_COUNT)};
    localparam logic [31:0] IDENT_VAL = {PRODUCT_CODE, 20'h0};

    always_comb begin
        rd_data = '0;
        if (rd_size == SZ_WORD) begin
            unique case (rd_addr)
                OFS_TYPE:  rd_data = TYPE_VAL;
                OFS_IDENT: rd_data = IDENT_VAL;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
    parameter int LINE_COUNT = 64,
    parameter int IDX_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [IDX_W-1:0]      fire_idx,
    output logic [LINE_COUNT-1:0] pulse
);
    logic [LINE_COUNT-1:0] pulse_d;
    logic [LINE_COUNT-1:0] pulse_q;

    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
        always_comb pulse_d[i] = fire && (fire_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame #(
    parameter int          BASE_ID      = 0,
    parameter int          LINE_COUNT   = 64,
    parameter logic [11:0] PRODUCT_CODE = 12'h051
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [11:0]           req_addr,
    input  logic [2:0]            req_size,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [31:0]           rsp_rdata,
    output logic [LINE_COUNT-1:0] irq_pulse
);
    import msi_frame_pkg::*;

    localparam int IDX_W = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1;

    // R11: configuration limits enforced at elaboration
    if (LINE_COUNT < 1 || LINE_COUNT > 128 || BASE_ID < 0 ||
        BASE_ID + ID_BIAS + LINE_COUNT > 1020) begin : g_bad_cfg
        $error("msi_doorbell_frame: illegal BASE_ID/LINE_COUNT");
    end

    rsp_state_t st_d;
    rsp_state_t st_q;

    logic             accept;
    logic             rd_accept;
    logic             size_ok_wr;
    logic             id_hit;
    logic             fire;
    logic [IDX_W-1:0] fire_idx;
    logic [31:0]      rd_data;
    logic [21:0]      unused_wdata_hi;

    assign unused_wdata_hi = req_wdata[31:10];

    assign req_ready = !st_q.rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rd_accept = accept && !req_write;
    assign size_ok_wr = (req_size == SZ_HALF) || (req_size == SZ_WORD);

    msi_read_mux #(
        .BASE_ID      (BASE_ID),
        .LINE_COUNT   (LINE_COUNT),
        .PRODUCT_CODE (PRODUCT_CODE)
    ) u_read_mux (
        .rd_addr (req_addr),
        .rd_size (req_size),
        .rd_data (rd_data)
    );

    msi_id_rebase #(
        .BASE_ID    (BASE_ID),
        .LINE_COUNT (LINE_COUNT),
        .IDX_W      (IDX_W)
    ) u_rebase (
        .irq_id   (req_wdata[9:0]),
        .in_range (id_hit),
        .line_idx (fire_idx)
    );

    assign fire = accept && req_write && size_ok_wr &&
                  (req_addr == OFS_DOORBELL) && id_hit;

    msi_pulse_bank #(
        .LINE_COUNT (LINE_COUNT),
        .IDX_W      (IDX_W)
    ) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .fire_idx (fire_idx),
        .pulse    (irq_pulse)
    );

    always_comb begin
        st_d = st_q;
        if (rd_accept) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_data  = rd_data;
        end else if (st_q.rsp_valid && rsp_ready) begin
            st_d.rsp_valid = 1'b0;
            st_d.rsp_data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_data;
endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
    parameter int LINE_COUNT = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic [2:0]            req_size,
    input logic                  rsp_valid,
    input logic                  rsp_ready,
    input logic [31:0]           rsp_rdata,
    input logic [LINE_COUNT-1:0] irq_pulse
);
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse)); // R10

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |-> $past(req_valid && req_ready && req_write)); // R6

    AST_BAD_SIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size != 3'd2 && req_size != 3'd4)
        |=> (irq_pulse == '0)); // R8

    AST_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (irq_pulse == '0)); // R8

    AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write)); // R5

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R5
endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(.LINE_COUNT(LINE_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .irq_pulse (irq_pulse)
);

// File: tb/msi_doorbell_frame_tb.sv
module msi_doorbell_frame_tb;
    localparam int          BASE  = 3;
    localparam int          LINES = 8;
    localparam logic [11:0] PCODE = 12'h5A3;
    localparam int          FIRST = BASE + 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [2:0]       req_size = 3'd4;
    logic [31:0]      req_wdata = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic [31:0]      rsp_rdata;
    logic [LINES-1:0] irq_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    msi_doorbell_frame #(
        .BASE_ID      (BASE),
        .LINE_COUNT   (LINES),
        .PRODUCT_CODE (PCODE)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [LINES-1:0] exp_pulse(input int id);
        if (id >= FIRST && id < FIRST + LINES) return LINES'(1) << (id - FIRST);
        return '0;
    endfunction

    // drive at a falling edge, let one rising edge accept it, release at the next falling edge
    task automatic do_req(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [2:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset pulses", 32'(irq_pulse), 32'h0);
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R10 reset req_ready", 32'(req_ready), 32'h1);

        // R6 R7: every 10-bit interrupt number, junk in the upper data bits
        for (int id = 0; id < 1024; id++) begin
            do_req(1'b1, 12'h040, {22'(id * 13 + 5), 10'(id)}, (id % 2 == 0) ? 3'd4 : 3'd2);
            chk((id >= FIRST && id < FIRST + LINES) ? "R6 doorbell hit" : "R7 doorbell miss",
                32'(irq_pulse), 32'(exp_pulse(id)));
        end

        // R8: write sizes at the doorbell
        for (int sz = 0; sz < 8; sz++) begin
            do_req(1'b1, 12'h040, 32'(FIRST + 2), 3'(sz));
            chk("R8 write size", 32'(irq_pulse),
                (sz == 2 || sz == 4) ? 32'(exp_pulse(FIRST + 2)) : 32'h0);
        end

        // R8: valid number written to every word offset and a few unaligned ones
        for (int w = 0; w < 1024; w++) begin
            do_req(1'b1, 12'(w * 4), 32'(FIRST + LINES - 1), 3'd4);
            chk("R8 write offset", 32'(irq_pulse),
                (w * 4 == 12'h040) ? 32'(exp_pulse(FIRST + LINES - 1)) : 32'h0);
        end
        for (int u = 1; u < 4; u++) begin
            do_req(1'b1, 12'(12'h040 + u), 32'(FIRST), 3'd4);
            chk("R8 unaligned write", 32'(irq_pulse), 32'h0);
        end

        // R1 R2 R3 R5: read every word offset
        for (int w = 0; w < 1024; w++) begin
            logic [31:0] e;
            if (w * 4 == 12'h008)      e = {16'(FIRST), 16'(LINES)};
            else if (w * 4 == 12'hFCC) e = {PCODE, 20'h0};
            else                       e = 32'h0;
            do_req(1'b0, 12'(w * 4), 32'hFFFF_FFFF, 3'd4);
            chk("R5 rsp_valid after read", 32'(rsp_valid), 32'h1);
            chk((w * 4 == 12'h008) ? "R1 type read" :
                (w * 4 == 12'hFCC) ? "R2 ident read" : "R3 zero read", rsp_rdata, e);
            chk("R8 read no pulse", 32'(irq_pulse), 32'h0);
        end

        // R4: read sizes at decoded offsets
        for (int sz = 0; sz < 8; sz++) begin
            do_req(1'b0, 12'h008, 32'h0, 3'(sz));
            chk("R4 read size type", rsp_rdata, (sz == 4) ? {16'(FIRST), 16'(LINES)} : 32'h0);
            do_req(1'b0, 12'hFCC, 32'h0, 3'(sz));
            chk("R4 read size ident", rsp_rdata, (sz == 4) ? {PCODE, 20'h0} : 32'h0);
        end

        // R9: back-to-back doorbells to different lines
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_size = 3'd4;
        req_wdata = 32'(FIRST);
        @(posedge clk); @(negedge clk);
        chk("R9 first pulse", 32'(irq_pulse), 32'(exp_pulse(FIRST)));
        req_wdata = 32'(FIRST + LINES - 1);
        @(posedge clk); @(negedge clk);
        chk("R9 second pulse", 32'(irq_pulse), 32'(exp_pulse(FIRST + LINES - 1)));
        req_wdata = 32'(FIRST + 3);
        @(posedge clk); @(negedge clk);
        chk("R9 third pulse", 32'(irq_pulse), 32'(exp_pulse(FIRST + 3)));
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R6 pulse lasts one cycle", 32'(irq_pulse), 32'h0);

        // R5 R9: stalled response, pending doorbell accepted on the retiring edge
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h008; req_size = 3'd4;
        @(posedge clk); @(negedge clk);
        req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'(FIRST + 5);
        chk("R5 stalled rsp_valid", 32'(rsp_valid), 32'h1);
        chk("R5 stalled req_ready", 32'(req_ready), 32'h0);
        held = rsp_rdata;
        chk("R1 stalled data", held, {16'(FIRST), 16'(LINES)});
        @(posedge clk); @(negedge clk);
        chk("R5 held data", rsp_rdata, held);
        chk("R5 write blocked", 32'(irq_pulse), 32'h0);
        chk("R5 still valid", 32'(rsp_valid), 32'h1);
        rsp_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R5 retired", 32'(rsp_valid), 32'h0);
        chk("R9 pulse on retire edge", 32'(irq_pulse), 32'(exp_pulse(FIRST + 5)));
        @(posedge clk); @(negedge clk);
        chk("R10 idle", 32'(irq_pulse), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule